// File: doc/BRIEF.md
# Restartable Baud Tick Generator

This block takes a fast system clock and produces a tick one clock wide at sixteen times the serial bit rate. It is meant to feed a serial transmitter and receiver. A 16-bit divisor is held in two byte-wide latches, one for the low byte and one for the high byte. A byte-wide write port, with a 3-bit address and an active-low single-cycle strobe, can reach these latches only while the divisor-access input is high.

The counter compares against a threshold. The threshold is the divisor shifted left by a parameterised number of zero prescale bits, four by default. The count sequence starts at 1 and reloads to 1, which cancels the one-cycle delay of the registered tick. As a result, ticks fall exactly one threshold apart.

Whenever either divisor byte is written, the count restarts from zero. This lets a new divisor take effect from a fresh count, instead of running on with a count value left over from the old period.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the low divisor byte is 11 and the high byte is 0, so the threshold is 176 with the default prescale of 4 bits. After reset `tick_o` is low, and the first tick appears on the threshold-th rising edge after reset is released.
- R2: A write is taken on a rising edge where `wr_ni` is low. With `div_access_i` high, address 0 loads the low divisor byte and address 1 loads the high byte. With `div_access_i` low, a write to address 0 or 1 changes neither byte and does not restart the count.
- R3: With no divisor write in between, two consecutive ticks are exactly threshold = {high, low, PRESCALE_W zeros} clock cycles apart.
- R4: A divisor write (address 0 or 1 with access high) clears the count. `tick_o` is low in the next cycle. The first tick under the new divisor comes threshold+1 cycles after the write edge, and ticks then repeat every threshold cycles.
- R5: Each tick is high for exactly one clock cycle whenever the threshold is above 1.
- R6: `baud_clk_no` is always the inverse of `tick_o`.
- R7: Writes to addresses 2 to 7 change neither divisor byte and do not restart the count, whatever the access bit is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_ni | input | 1 | Active-low write strobe, one cycle per write |
| addr_i | input | 3 | Write address |
| data_i | input | 8 | Write data |
| div_access_i | input | 1 | Divisor-access enable |
| tick_o | output | 1 | Registered baud tick, one cycle wide |
| baud_clk_no | output | 1 | Active-low copy of the tick |

## Verification
Two events can fall in the same cycle: a divisor write that restarts the count, and the compare match that would otherwise raise a tick. The bench provokes this by issuing writes at arbitrary points in the count, including back-to-back writes to both bytes. It also writes to the same byte again while a count is still running. On every clock, a behavioural countdown model judges whether the restart suppressed the tick and whether it delayed the next tick by exactly threshold+1 cycles.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  localparam int unsigned DIV_W = 16;
  localparam logic [2:0] ADDR_DIV_LO = 3'd0;
  localparam logic [2:0] ADDR_DIV_HI = 3'd1;
  localparam logic [7:0] RST_DIV_LO  = 8'd11;
  localparam logic [7:0] RST_DIV_HI  = 8'd0;

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] lo;
  } divisor_t;
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs
  import baud_tick_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_ni,
  input  logic [2:0] addr_i,
  input  logic [7:0] data_i,
  input  logic       div_access_i,
  output divisor_t   div_o,
  output logic       restart_o
);
  logic wr_lo, wr_hi;

  assign wr_lo     = !wr_ni && div_access_i && (addr_i == ADDR_DIV_LO);
  assign wr_hi     = !wr_ni && div_access_i && (addr_i == ADDR_DIV_HI);
  assign restart_o = wr_lo || wr_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o.lo <= RST_DIV_LO;
      div_o.hi <= RST_DIV_HI;
    end else begin
      if (wr_lo) div_o.lo <= data_i;
      if (wr_hi) div_o.hi <= data_i;
    end
  end
endmodule

// File: rtl/baud_counter.sv
module baud_counter #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);
  logic match;

  assign match = (cnt_o == thr_i);

  // start and reload at 1 so the registered tick keeps an exact thr_i period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= CNT_W'(1);
      tick_o <= 1'b0;
    end else if (restart_i) begin
      cnt_o  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= match;
      cnt_o  <= match ? CNT_W'(1) : cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned PRESCALE_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_ni,
  input  logic [2:0] addr_i,
  input  logic [7:0] data_i,
  input  logic       div_access_i,
  output logic       tick_o,
  output logic       baud_clk_no
);
  localparam int unsigned CNT_W = DIV_W + PRESCALE_W;

  divisor_t         div_w;
  logic             restart_w;
  logic [CNT_W-1:0] thr_w;
  logic [CNT_W-1:0] cnt_w;

  baud_div_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_ni       (wr_ni),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .div_access_i(div_access_i),
    .div_o       (div_w),
    .restart_o   (restart_w)
  );

  generate
    if (PRESCALE_W == 0) begin : g_noscale
      assign thr_w = div_w;
    end else begin : g_scale
      assign thr_w = {div_w, {PRESCALE_W{1'b0}}};
    end
  endgenerate

  baud_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .thr_i    (thr_w),
    .restart_i(restart_w),
    .cnt_o    (cnt_w),
    .tick_o   (tick_o)
  );

  assign baud_clk_no = ~tick_o;
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_ni,
  input logic [2:0]       addr_i,
  input logic             div_access_i,
  input logic [15:0]      div_w,
  input logic [CNT_W-1:0] thr_w,
  input logic [CNT_W-1:0] cnt_w,
  input logic             tick_o
);
  logic div_wr;
  assign div_wr = !wr_ni && div_access_i && (addr_i inside {3'd0, 3'd1});

  // R4
  restart_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_wr |=> (cnt_w == '0) && !tick_o);

  // R2
  locked_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && !div_access_i) |=> $stable(div_w));

  // R7
  other_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && (addr_i > 3'd1)) |=> $stable(div_w));

  // R5
  one_cycle_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (thr_w > CNT_W'(1)) && !div_wr) |=> !tick_o);

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_w != '0) |-> (cnt_w <= thr_w));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_ni       (wr_ni),
  .addr_i      (addr_i),
  .div_access_i(div_access_i),
  .div_w       (div_w),
  .thr_w       (thr_w),
  .cnt_w       (cnt_w),
  .tick_o      (tick_o)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] data = '0;
  logic       acc = 1'b0;
  logic       tick, bclk_n;

  int checks = 0, errors = 0;
  bit done = 0;

  baud_tick_gen #(.PRESCALE_W(PRE)) i_baud_tick_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_ni(wr_n), .addr_i(addr), .data_i(data),
    .div_access_i(acc), .tick_o(tick), .baud_clk_no(bclk_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural countdown model
  int m_lo, m_hi, rem, thr;
  bit exp_tick, restarted, first;
  int last_tick_cyc, cyc;
  string phase = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo = 11; m_hi = 0; thr = 176; rem = 176; exp_tick = 0;
      restarted = 1; first = 1; cyc = 0;
    end else begin
      cyc++;
      if (!wr_n && acc && addr <= 3'd1) begin
        if (addr == 3'd0) m_lo = data; else m_hi = data;
        thr = ((m_hi << 8) | m_lo) << PRE;
        rem = thr + 1; exp_tick = 0; restarted = 1;
      end else begin
        rem--;
        exp_tick = (rem == 0);
        if (rem == 0) rem = thr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(tick == exp_tick, phase, tick, exp_tick);
    chk(bclk_n == !tick, "R6", bclk_n, !tick);
    if (tick) begin
      if (!restarted) chk(cyc - last_tick_cyc == thr, "R3", cyc - last_tick_cyc, thr);
      else if (first) chk(cyc == thr, "R1", cyc, thr);
      last_tick_cyc = cyc; restarted = 0; first = 0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic ac);
    @(negedge clk); wr_n = 0; addr = a; data = d; acc = ac;
    @(negedge clk); wr_n = 1; acc = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*2 + 2);
    chk(tick == 0, "R1", tick, 0);
    chk(bclk_n == 1, "R1", bclk_n, 1);
    @(negedge clk); rst_n = 1;
    idle(400);                       // R1 R3 with reset divisor
    phase = "R4"; idle(37);
    wr(3'd0, 8'd3, 1'b1);            // R2 R4 mid-count change, thr 48
    idle(200);
    phase = "R2";
    wr(3'd0, 8'd9, 1'b0);            // ignored without access
    idle(150);
    phase = "R7";
    wr(3'd5, 8'd1, 1'b1);
    wr(3'd2, 8'd0, 1'b1);
    idle(150);
    phase = "R4";
    wr(3'd1, 8'd1, 1'b1);            // thr (259<<4)
    idle(9000);
    wr(3'd1, 8'd0, 1'b1);            // back-to-back bytes
    wr(3'd0, 8'd1, 1'b1);            // thr 16
    idle(23);
    wr(3'd0, 8'd1, 1'b1);            // same value rewrite mid-count
    idle(100);
    phase = "R5";
    wr(3'd0, 8'd2, 1'b1);
    idle(200);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule